// File: doc/BRIEF.md
# Protected Program Sequencing Controller

This block sits behind a serial slave front end that has already turned the serial stream into single-cycle events: chip-select falling and rising, a decoded opcode, a decoded address and one pulse per complete data byte. It also samples a flag saying whether any bits of an incomplete byte are still waiting. The block holds the program enable latch and the status register: protect-enable bit, two block-lock bits and the program-in-progress flag. It decides whether a request to program a 32-byte sector of the array, or to program the status register, is accepted. It also decides whether the request completes when chip select rises.

An accepted and completed request raises the in-progress flag for a fixed number of cycles. After that the status fields are updated, or the controller emits a single-cycle sector write carrying all the collected bytes. A protect pin combines with the protect-enable bit into a hardware lock. While that lock is active, the status register cannot be rewritten, and this includes the protect-enable bit itself. The front end presents at most one event per clock cycle.

Top module: `psq_ctrl`

## Requirements
- R1: The enable latch (status bit 1) is set only by a frame holding the enable opcode 0x06 and nothing else. The frame must end with no data byte, no address and no pending bits. Any frame with more after the opcode leaves the latch unchanged.
- R2: A sector-program request (opcode 0x02) or a status-program request (opcode 0x01) that arrives while the latch is clear has no effect on memory or status.
- R3: A sector program commits only if chip select rises when exactly 32 data bytes have arrived and no bits are pending. With fewer bytes, more bytes or pending bits, nothing is written and the latch keeps its value.
- R4: The program address must have its low five bits at zero and must name a sector that is not block-locked. Otherwise the request is rejected, nothing is written and the latch clears.
- R5: The block-lock field (status bits 3:2) locks sectors as follows: 00 locks none, 01 locks the upper quarter, 10 locks the upper half and 11 locks all sectors. A locked sector is never written.
- R6: The hardware lock is active when the protect pin is low and the protect-enable bit (status bit 7) is 1. While it is active, a status-program request is refused and clears the latch, and the status fields stay unchanged.
- R7: A status-program request takes exactly one data byte. If any of bits 0, 1, 4, 5 or 6 of that byte is 1, the request is rejected and the latch clears. Otherwise bit 7 goes to protect-enable and bits 3:2 go to the block-lock field. A frame with zero bytes or two or more bytes is abandoned and the latch keeps its value.
- R8: The in-progress flag (status bit 0, also the pip port) is high for exactly BUSY_CYC cycles. It starts in the cycle after the completing chip-select rise. The status update or the one-cycle sector write appears in the first cycle after the flag falls, with data byte i at bits 8i+7:8i.
- R9: The latch clears when a program or status request completes.
- R10: While the in-progress flag is high, enable, program and status requests are ignored.
- R11: After reset the status reads 0x00 and no write is issued; status bits 6:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_pin | input | 1 | Protect pin, low requests hardware lock |
| cs_fall | input | 1 | Chip select went low (frame start) |
| cs_rise | input | 1 | Chip select went high (frame end) |
| bits_pending | input | 1 | Some bits of an incomplete byte are held by the front end |
| op_valid | input | 1 | Opcode byte received |
| op_code | input | 8 | Received opcode |
| addr_valid | input | 1 | Address received |
| addr | input | ADDR_W | Received address |
| byte_valid | input | 1 | Data byte received |
| byte_data | input | 8 | Received data byte |
| status_rd | output | 8 | Status: bit7 protect-enable, bits3:2 block lock, bit1 latch, bit0 in progress |
| pip | output | 1 | Program in progress |
| arr_we | output | 1 | One-cycle sector write strobe |
| arr_sector | output | ADDR_W-5 | Sector index for the write |
| arr_data | output | 256 | Sector data, byte i at bits 8i+7:8i |

## Verification
The assertions check several rules on every cycle. No commit may start while the latch is clear or while the in-progress flag is high, and the latch must be clear right after a commit starts. The protect and lock fields must hold still whenever the hardware lock is active. Every sector write must follow the busy period and must never hit a locked sector. The bench scenarios are what show the frame-level rules: the exact-32-byte chip-select rule, the abandoned and rejected paths with their different latch outcomes, the must-be-zero bit check, the lock-region decoding and the exact busy length, all compared with written sector data held in a scoreboard.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ARR,
    ST_SR,
    ST_DISC
  } psq_state_e;

  typedef enum logic {
    JOB_ARR,
    JOB_SR
  } psq_job_e;

  // Bits that a status write must leave at zero.
  localparam logic [7:0] SR_ZERO_MASK = 8'h73;

  function automatic logic psq_block_locked(int unsigned sector, int unsigned nsec,
                                            logic [1:0] bl);
    logic r;
    case (bl)
      2'b00:   r = 1'b0;
      2'b01:   r = (sector >= nsec - nsec / 4);
      2'b10:   r = (sector >= nsec / 2);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

  function automatic logic psq_sr_legal(logic [7:0] d);
    return (d & SR_ZERO_MASK) == 8'h00;
  endfunction

  function automatic logic psq_hw_lock(logic pin, logic ppen);
    return !pin && ppen;
  endfunction

endpackage

// File: rtl/psq_guard.sv
module psq_guard
  import psq_pkg::*;
#(
  parameter int NSEC  = 2048,
  parameter int SEC_W = 11
) (
  input  logic             prot_pin,
  input  logic             ppen,
  input  logic [1:0]       bl,
  input  logic [SEC_W-1:0] sector,
  output logic             hw_lock,
  output logic             sec_locked
);

  always_comb begin
    hw_lock    = psq_hw_lock(prot_pin, ppen);
    sec_locked = psq_block_locked(int'(sector), NSEC, bl);
  end

  // R5: full lock covers every sector
  always_comb begin
    a_r5_all_locked: assert (!(bl == 2'b11) || sec_locked);
  end

endmodule

// File: rtl/psq_collect.sv
module psq_collect #(
  parameter int SECTOR_BYTES = 32,
  parameter int CNT_W        = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      load,
  input  logic [7:0]                din,
  output logic [CNT_W-1:0]          cnt,
  output logic                      ovf,
  output logic [SECTOR_BYTES*8-1:0] data_flat
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(SECTOR_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             full;

  assign full = (cnt_q == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (load) begin
      if (full) ovf_q <= 1'b1;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < SECTOR_BYTES; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   slot_q <= 8'h00;
      else if (load && !clr && cnt_q == CNT_W'(g))  slot_q <= din;
    end
    assign data_flat[g*8 +: 8] = slot_q;
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;

  // R3: the byte count never passes one sector
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

endmodule

// File: rtl/psq_busy.sv
module psq_busy #(
  parameter int BUSY_CYC = 64,
  parameter int W        = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pip,
  output logic done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= W'(BUSY_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign pip  = (cnt_q != '0);
  assign done = (cnt_q == W'(1));

  // R8: a start raises the flag on the next cycle
  a_r8_pip_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> pip);

  // R10: no restart while busy
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    pip |-> !start);

endmodule

// File: rtl/psq_ctrl.sv
module psq_ctrl
  import psq_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          SECTOR_BYTES = 32,
  parameter int          BUSY_CYC     = 64,
  parameter logic [7:0]  OP_PREN      = 8'h06,
  parameter logic [7:0]  OP_PROG      = 8'h02,
  parameter logic [7:0]  OP_PRSR      = 8'h01
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              prot_pin,
  input  logic                              cs_fall,
  input  logic                              cs_rise,
  input  logic                              bits_pending,
  input  logic                              op_valid,
  input  logic [7:0]                        op_code,
  input  logic                              addr_valid,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              byte_valid,
  input  logic [7:0]                        byte_data,
  output logic [7:0]                        status_rd,
  output logic                              pip,
  output logic                              arr_we,
  output logic [ADDR_W-$clog2(SECTOR_BYTES)-1:0] arr_sector,
  output logic [SECTOR_BYTES*8-1:0]         arr_data
);

  localparam int OFS_W  = $clog2(SECTOR_BYTES);
  localparam int SEC_W  = ADDR_W - OFS_W;
  localparam int NSEC   = 1 << SEC_W;
  localparam int CNT_W  = $clog2(SECTOR_BYTES + 1);
  localparam int BUSY_W = $clog2(BUSY_CYC + 1);

  psq_state_e       st_q;
  psq_job_e         job_q;
  logic             latch_q, ppen_q, pren_arm_q, addr_ok_q;
  logic [1:0]       bl_q, sr_cnt_q;
  logic [7:0]       sr_byte_q;
  logic [SEC_W-1:0] sector_q;
  logic             arr_we_q;

  // Internal events, named for the assertions
  logic             hw_lock, addr_sec_locked, addr_good;
  logic             op_prog, op_prsr, op_pren;
  logic             arr_start, sr_start, sr_refuse, addr_bad;
  logic             arr_done_ok, sr_done_ok, sr_bad_data;
  logic             pren_set, busy_start, reject, busy_done;
  logic [CNT_W-1:0] byte_cnt;
  logic             byte_ovf;
  logic             col_load;

  psq_guard #(.NSEC(NSEC), .SEC_W(SEC_W)) u_guard (
    .prot_pin  (prot_pin),
    .ppen      (ppen_q),
    .bl        (bl_q),
    .sector    (addr[ADDR_W-1:OFS_W]),
    .hw_lock   (hw_lock),
    .sec_locked(addr_sec_locked)
  );

  assign col_load = (st_q == ST_ARR) && byte_valid && addr_ok_q;

  psq_collect #(.SECTOR_BYTES(SECTOR_BYTES), .CNT_W(CNT_W)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (arr_start),
    .load     (col_load),
    .din      (byte_data),
    .cnt      (byte_cnt),
    .ovf      (byte_ovf),
    .data_flat(arr_data)
  );

  psq_busy #(.BUSY_CYC(BUSY_CYC), .W(BUSY_W)) u_busy (
    .clk  (clk),
    .rst_n(rst_n),
    .start(busy_start),
    .pip  (pip),
    .done (busy_done)
  );

  // Request decode
  always_comb begin
    op_pren   = op_valid && (st_q == ST_OPC) && (op_code == OP_PREN);
    op_prog   = op_valid && (st_q == ST_OPC) && (op_code == OP_PROG);
    op_prsr   = op_valid && (st_q == ST_OPC) && (op_code == OP_PRSR);
    arr_start = op_prog && latch_q && !pip;
    sr_start  = op_prsr && latch_q && !pip && !hw_lock;
    sr_refuse = op_prsr && latch_q && !pip && hw_lock;
    addr_good = (addr[OFS_W-1:0] == '0) && !addr_sec_locked;
    addr_bad  = (st_q == ST_ARR) && addr_valid && !addr_ok_q && !addr_good;
  end

  // Frame-end decisions
  always_comb begin
    arr_done_ok = cs_rise && (st_q == ST_ARR) && addr_ok_q && !byte_ovf
                  && (byte_cnt == CNT_W'(SECTOR_BYTES)) && !bits_pending;
    sr_done_ok  = cs_rise && (st_q == ST_SR) && (sr_cnt_q == 2'd1) && !bits_pending
                  && psq_sr_legal(sr_byte_q);
    sr_bad_data = cs_rise && (st_q == ST_SR) && (sr_cnt_q == 2'd1) && !bits_pending
                  && !psq_sr_legal(sr_byte_q);
    pren_set    = cs_rise && pren_arm_q && !bits_pending && !pip;
    busy_start  = arr_done_ok || sr_done_ok;
    reject      = addr_bad || sr_refuse || sr_bad_data;
  end

  // Frame tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      pren_arm_q <= 1'b0;
      addr_ok_q  <= 1'b0;
      sr_cnt_q   <= 2'd0;
      sr_byte_q  <= 8'h00;
      sector_q   <= '0;
    end else if (cs_fall) begin
      st_q       <= ST_OPC;
      pren_arm_q <= 1'b0;
      addr_ok_q  <= 1'b0;
      sr_cnt_q   <= 2'd0;
    end else if (cs_rise) begin
      st_q       <= ST_IDLE;
      pren_arm_q <= 1'b0;
    end else begin
      case (st_q)
        ST_OPC: begin
          if (op_valid) begin
            if (op_pren && !pip) begin
              pren_arm_q <= 1'b1;
              st_q       <= ST_DISC;
            end else if (arr_start) begin
              st_q <= ST_ARR;
            end else if (sr_start) begin
              st_q <= ST_SR;
            end else begin
              st_q <= ST_DISC;
            end
          end
        end
        ST_ARR: begin
          if (addr_valid && !addr_ok_q) begin
            if (addr_good) begin
              addr_ok_q <= 1'b1;
              sector_q  <= addr[ADDR_W-1:OFS_W];
            end else begin
              st_q <= ST_DISC;
            end
          end else if (byte_valid && !addr_ok_q) begin
            st_q <= ST_DISC;
          end
        end
        ST_SR: begin
          if (byte_valid) begin
            if (sr_cnt_q == 2'd0) sr_byte_q <= byte_data;
            if (sr_cnt_q != 2'd2) sr_cnt_q  <= sr_cnt_q + 2'd1;
          end
        end
        ST_DISC: begin
          if (byte_valid || addr_valid || op_valid) pren_arm_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // Enable latch, job kind, commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= 1'b0;
      job_q    <= JOB_ARR;
      ppen_q   <= 1'b0;
      bl_q     <= 2'b00;
      arr_we_q <= 1'b0;
    end else begin
      if (busy_start || reject) latch_q <= 1'b0;
      else if (pren_set)        latch_q <= 1'b1;

      if (busy_start) job_q <= arr_done_ok ? JOB_ARR : JOB_SR;

      arr_we_q <= busy_done && (job_q == JOB_ARR);

      if (busy_done && (job_q == JOB_SR) && !hw_lock) begin
        ppen_q <= sr_byte_q[7];
        bl_q   <= sr_byte_q[3:2];
      end
    end
  end

  assign status_rd  = {ppen_q, 3'b000, bl_q, latch_q, pip};
  assign arr_we     = arr_we_q;
  assign arr_sector = sector_q;

  // R2: a commit only begins with the latch set
  a_r2_commit_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    busy_start |-> latch_q);

  // R9: latch is clear after a commit starts
  a_r9_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    busy_start |=> !latch_q);

  // R6: lock freezes protect-enable and block-lock fields
  a_r6_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    hw_lock |=> ($stable(ppen_q) && $stable(bl_q)));

  // R8: a sector write follows the busy period
  a_r8_we_after_pip: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_q |-> ($past(pip) && !pip));

  // R5: a locked sector is never written
  a_r5_no_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_q |-> !psq_block_locked(int'(sector_q), NSEC, bl_q));

  // R10: nothing starts while busy
  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    pip |-> !(busy_start || pren_set));

endmodule

// File: tb/psq_ctrl_tb.sv
module psq_ctrl_tb_top;

  localparam int CLK_NS = 10;
  localparam int BUSY   = 12;
  localparam int AW     = 16;
  localparam int SB     = 32;
  localparam int SW     = AW - 5;

  typedef struct packed {
    logic [SW-1:0]   sector;
    logic [SB*8-1:0] data;
  } wr_item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          prot_pin = 1'b1;
  logic          cs_fall = 1'b0, cs_rise = 1'b0, bits_pending = 1'b0;
  logic          op_valid = 1'b0, addr_valid = 1'b0, byte_valid = 1'b0;
  logic [7:0]    op_code = 8'h00, byte_data = 8'h00;
  logic [AW-1:0] addr = '0;
  logic [7:0]    status_rd;
  logic          pip, arr_we;
  logic [SW-1:0] arr_sector;
  logic [SB*8-1:0] arr_data;

  int checks = 0;
  int errors = 0;
  wr_item_t exp_q[$];

  always #(CLK_NS/2) clk = ~clk;

  psq_ctrl #(.ADDR_W(AW), .SECTOR_BYTES(SB), .BUSY_CYC(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .prot_pin(prot_pin),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .bits_pending(bits_pending),
    .op_valid(op_valid), .op_code(op_code),
    .addr_valid(addr_valid), .addr(addr),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .status_rd(status_rd), .pip(pip),
    .arr_we(arr_we), .arr_sector(arr_sector), .arr_data(arr_data)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every sector write
  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2/R3/R4 unexpected write actual=sector 0x%0h expected=none",
                 arr_sector);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        if (e.sector != arr_sector || e.data != arr_data) begin
          errors++;
          $display("FAIL R8 write actual=sector 0x%0h data 0x%0h expected=sector 0x%0h data 0x%0h",
                   arr_sector, arr_data, e.sector, e.data);
        end
      end
    end
  end

  function automatic logic [SB*8-1:0] pattern(logic [7:0] seed, int n);
    logic [SB*8-1:0] d = '0;
    for (int i = 0; i < n && i < SB; i++) d[i*8 +: 8] = seed ^ 8'(i * 13);
    return d;
  endfunction

  task automatic quiet();
    cs_fall = 0; cs_rise = 0; bits_pending = 0;
    op_valid = 0; addr_valid = 0; byte_valid = 0;
  endtask

  task automatic fbeg();
    @(negedge clk); quiet(); cs_fall = 1;
  endtask

  task automatic fop(logic [7:0] op);
    @(negedge clk); quiet(); op_valid = 1; op_code = op;
  endtask

  task automatic faddr(logic [AW-1:0] a);
    @(negedge clk); quiet(); addr_valid = 1; addr = a;
  endtask

  task automatic fbyte(logic [7:0] b);
    @(negedge clk); quiet(); byte_valid = 1; byte_data = b;
  endtask

  task automatic fend(logic bp);
    @(negedge clk); quiet(); cs_rise = 1; bits_pending = bp;
    @(negedge clk); quiet();
  endtask

  task automatic pren();
    fbeg(); fop(8'h06); fend(1'b0);
  endtask

  task automatic prog(logic [AW-1:0] a, int n, logic [7:0] seed, logic bp);
    logic [SB*8-1:0] d;
    d = pattern(seed, SB + 1);
    fbeg(); fop(8'h02); faddr(a);
    for (int i = 0; i < n; i++) fbyte(i < SB ? d[i*8 +: 8] : 8'hEE);
    fend(bp);
  endtask

  task automatic prsr(logic [7:0] v, int n);
    fbeg(); fop(8'h01);
    for (int i = 0; i < n; i++) fbyte(v);
    fend(1'b0);
  endtask

  // Driver side of the scoreboard: expected write
  task automatic expect_wr(logic [AW-1:0] a, logic [7:0] seed);
    wr_item_t e;
    e.sector = a[AW-1:5];
    e.data   = pattern(seed, SB);
    exp_q.push_back(e);
  endtask

  task automatic wait_busy(string req);
    int n = 0;
    while (pip) begin n++; @(negedge clk); end
    chk(req, n, BUSY);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset status", status_rd, 8'h00);
    chk("R11 reset write", arr_we, 0);

    // R1: extra byte or pending bits block the latch
    fbeg(); fop(8'h06); fbyte(8'h00); fend(1'b0);
    chk("R1 enable with trailing byte", status_rd, 8'h00);
    fbeg(); fop(8'h06); fend(1'b1);
    chk("R1 enable with pending bits", status_rd, 8'h00);
    pren();
    chk("R1 clean enable", status_rd, 8'h02);

    // R3/R8/R9: good program of sector 3
    expect_wr(16'h0060, 8'h5A);
    prog(16'h0060, 32, 8'h5A, 1'b0);
    chk("R8 busy flag after commit", status_rd, 8'h01);
    wait_busy("R8 busy length");
    chk("R9 latch cleared after commit", status_rd, 8'h00);

    // R2: program and status request without latch
    prog(16'h0080, 32, 8'h11, 1'b0);
    chk("R2 program without latch", status_rd, 8'h00);
    prsr(8'h8C, 1);
    repeat (BUSY + 2) @(negedge clk);
    chk("R2 status write without latch", status_rd, 8'h00);

    // R3: abandoned frames keep the latch and write nothing
    pren();
    prog(16'h0080, 31, 8'h22, 1'b0);
    chk("R3 31 bytes abandoned", status_rd, 8'h02);
    prog(16'h0080, 33, 8'h22, 1'b0);
    chk("R3 33 bytes abandoned", status_rd, 8'h02);
    prog(16'h0080, 32, 8'h22, 1'b1);
    chk("R3 pending bits abandoned", status_rd, 8'h02);

    // R4: unaligned address rejected, latch clears
    prog(16'h0081, 32, 8'h22, 1'b0);
    chk("R4 unaligned rejected", status_rd, 8'h00);

    // R7: must-zero bits, byte count
    pren(); prsr(8'h10, 1);
    chk("R7 illegal bits rejected", status_rd, 8'h00);
    pren(); prsr(8'h84, 2);
    chk("R7 two bytes abandoned", status_rd, 8'h02);
    prsr(8'h84, 1);
    chk("R8 busy after status write", status_rd, 8'h01);
    wait_busy("R8 busy length status");
    chk("R7 status fields written", status_rd, 8'h84);

    // R5: upper quarter locked (sector 1600), sector 1535 free
    pren(); prog(16'hC800, 32, 8'h33, 1'b0);
    chk("R5 locked sector rejected", status_rd, 8'h84);
    pren();
    expect_wr(16'hBFE0, 8'h44);
    prog(16'hBFE0, 32, 8'h44, 1'b0);
    wait_busy("R8 busy length 2");
    chk("R5 unlocked sector done", status_rd, 8'h84);

    // R6: hardware lock freezes protect-enable
    prot_pin = 1'b0;
    pren(); prsr(8'h00, 1);
    repeat (BUSY + 2) @(negedge clk);
    chk("R6 status write refused", status_rd, 8'h84);
    prot_pin = 1'b1;
    pren(); prsr(8'h00, 1);
    wait_busy("R8 busy length 3");
    chk("R6 unlocked status write", status_rd, 8'h00);

    // R10: enable while busy is ignored
    pren();
    expect_wr(16'h00A0, 8'h77);
    prog(16'h00A0, 32, 8'h77, 1'b0);
    pren();
    chk("R10 still busy", pip, 1);
    while (pip) @(negedge clk);
    @(negedge clk);
    chk("R10 enable during busy ignored", status_rd, 8'h00);

    repeat (4) @(negedge clk);
    chk("R3 all expected writes seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule